// File: doc/BRIEF.md
# Serial EEPROM Boot Loader

After reset this block reads a small serial EEPROM that is organised in 16-bit words and uses a four-wire Microwire-style interface. It reads three header words: a vendor identifier, a product identifier and a control word. The low byte of the control word is a magic code. If that code matches, the header is accepted. The control word then decides how the attached audio codec is set up. The block either writes a list of address/data pairs taken from the EEPROM, or writes a fixed table of defaults held in the block, or writes nothing.

If the magic code does not match, the block behaves as if no EEPROM were fitted. It keeps its default identifiers and writes the built-in table. Codec register writes leave the block through a valid/ready handshake; the codec link that consumes them lies outside the block. When the last write has been accepted, the block raises a done flag and stays quiet until the next reset.

Top module: `eeboot_loader`

## Requirements
- R1: During and right after reset, `ee_cs`, `ee_sk`, `cw_valid`, `boot_done` and `ee_present` are 0, and `vendor_id`/`product_id` equal the parameters `DEF_VID`/`DEF_PID`.
- R2: Every high phase of `ee_sk` lasts exactly `HALF_CLKS` clock cycles. `ee_sk` is high only while `ee_cs` is high. `ee_cs` stays low for at least `HALF_CLKS` cycles between two word reads.
- R3: Each word read is one `ee_cs` frame of 26 `ee_sk` rising edges. Over the first nine rising edges `ee_di` carries the bits 1, 1, 0 and then the 6-bit word address, MSB first. The level of `ee_do` at rising edge 10 is discarded. The levels at rising edges 11 to 26 form the 16-bit word, MSB first.
- R4: Words 0, 1 and 2 are read first and in that order. When bits 7:0 of word 2 equal 0xAB, `ee_present` becomes 1 and `vendor_id`/`product_id` take words 0 and 1. After `boot_done`, none of these outputs change.
- R5: When bits 7:0 of word 2 differ from 0xAB, `ee_present` stays 0, the IDs keep their defaults, `vol_sel` is 0 and the built-in table is written.
- R6: With a valid header and bit 13 of the control word set, the built-in table is written and bits 11:8 are ignored. No word past word 2 is read. The table is, in write order (address/data, hex): 18/0808, 10/8808, 0E/0008, 04/0000, 1A/0000, 1C/0000, 2A/0001.
- R7: With a valid header, bit 13 clear and a nonzero count N in bits 11:8, words 3 to 2+2N are read in order. Each pair gives one write: the address is the high byte of the first word (its low byte is ignored) and the data is the whole second word.
- R8: With a valid header, bit 13 clear and a count of 0, no codec write is issued and only words 0 to 2 are read.
- R9: With a valid header, `vol_sel` equals bit 12 of the control word: 0 selects the auxiliary line-out volume register (0x04), 1 the stereo line-out register (0x02). Bits 15:14 have no effect.
- R10: `rom_opt` equals bit 1 of `product_id` when `ee_present` is 1, and follows the `rom_strap` input otherwise.
- R11: While `cw_valid` is high and `cw_ready` is low, `cw_valid`, `cw_addr` and `cw_data` hold. Each cycle with both high transfers exactly one write, in the order given above.
- R12: `boot_done` rises after the final write is accepted, or after the header when nothing is written. From then on it stays high and `ee_cs` and `cw_valid` stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ee_cs | output | 1 | EEPROM chip select |
| ee_sk | output | 1 | EEPROM serial clock |
| ee_di | output | 1 | Serial data into the EEPROM |
| ee_do | input | 1 | Serial data out of the EEPROM |
| rom_strap | input | 1 | Strap level used for `rom_opt` when no EEPROM is accepted |
| vendor_id | output | 16 | Vendor identifier |
| product_id | output | 16 | Product identifier |
| ee_present | output | 1 | Header accepted (magic code matched) |
| rom_opt | output | 1 | ROM option bit |
| vol_sel | output | 1 | Volume-control target select |
| cw_valid | output | 1 | Codec write request |
| cw_addr | output | 8 | Codec register address |
| cw_data | output | 16 | Codec register data |
| cw_ready | input | 1 | Codec write accepted |
| boot_done | output | 1 | Boot sequence finished |

## Verification
Some rules hold on every cycle, and the assertions check those. They cover the serial clock: its high-phase width, its confinement to chip-select frames and the count of rising edges per frame. They also cover the hold of a pending codec write under back-pressure, the defaults kept when the header is rejected, and the quiet, frozen state after completion. Other behaviour can only be shown by the directed scenarios, which model the EEPROM's memory and the codec's ready line. These cover which words are fetched and in what order, how the control word picks among table, EEPROM pairs and nothing, the ignored low byte of address words, and the source of the ROM option bit.

// File: rtl/eeboot_pkg.sv
package eeboot_pkg;

  typedef struct packed {
    logic [7:0]  addr;
    logic [15:0] data;
  } cw_entry_t;

  typedef enum logic [2:0] {
    PH_VID, PH_PID, PH_CTRL, PH_PADDR, PH_PDATA
  } phase_e;

  localparam int TBL_LEN = 7;

  // Built-in codec defaults, indexed in write order.
  function automatic cw_entry_t dflt_entry(input logic [2:0] idx);
    cw_entry_t e;
    case (idx)
      3'd0:    e = '{addr: 8'h18, data: 16'h0808};
      3'd1:    e = '{addr: 8'h10, data: 16'h8808};
      3'd2:    e = '{addr: 8'h0E, data: 16'h0008};
      3'd3:    e = '{addr: 8'h04, data: 16'h0000};
      3'd4:    e = '{addr: 8'h1A, data: 16'h0000};
      3'd5:    e = '{addr: 8'h1C, data: 16'h0000};
      3'd6:    e = '{addr: 8'h2A, data: 16'h0001};
      default: e = '{addr: 8'h00, data: 16'h0000};
    endcase
    return e;
  endfunction

  // Header acceptance: low byte of control word against the magic value.
  function automatic logic header_ok(input logic [15:0] ctrl, input logic [7:0] magic);
    return ctrl[7:0] == magic;
  endfunction

endpackage

// File: rtl/eeboot_mw_reader.sv
module eeboot_mw_reader #(
  parameter int HALF_CLKS = 500,
  parameter int ADDR_BITS = 6,
  parameter int WORD_BITS = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic [ADDR_BITS-1:0] addr,
  output logic                 busy,
  output logic                 done,
  output logic [WORD_BITS-1:0] word,
  output logic                 cs,
  output logic                 sk,
  output logic                 di,
  input  logic                 do_in
);
  localparam int CMD_BITS = 3 + ADDR_BITS;
  localparam int TOTAL    = CMD_BITS + 1 + WORD_BITS;
  localparam int PW       = $clog2(HALF_CLKS + 1);
  localparam int KW       = $clog2(TOTAL + 1);

  typedef enum logic [1:0] {R_IDLE, R_RUN, R_GAP} rstate_e;

  rstate_e              st;
  logic [PW-1:0]        ph;
  logic [KW-1:0]        k;
  logic [ADDR_BITS-1:0] addr_q;
  logic [WORD_BITS-1:0] sh;

  // Level on the data line for serial clock pulse n (1-based).
  function automatic logic cmd_bit(input int n, input logic [ADDR_BITS-1:0] a);
    logic [CMD_BITS-1:0] c;
    c = {3'b110, a};
    if (n >= 1 && n <= CMD_BITS) return c[CMD_BITS-n];
    return 1'b0;
  endfunction

  wire phase_end = (ph == PW'(HALF_CLKS - 1));
  wire data_bit  = (int'(k) > CMD_BITS + 1);
  wire last_bit  = (k == KW'(TOTAL));

  assign busy = (st != R_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= R_IDLE; cs <= 1'b0; sk <= 1'b0; di <= 1'b0;
      ph <= '0; k <= '0; addr_q <= '0; sh <= '0;
      done <= 1'b0; word <= '0;
    end else begin
      done <= 1'b0;
      unique case (st)
        R_IDLE: if (start) begin
          cs <= 1'b1; sk <= 1'b0; k <= KW'(1); ph <= '0;
          addr_q <= addr; di <= cmd_bit(1, addr); st <= R_RUN;
        end
        R_RUN: if (phase_end) begin
          ph <= '0;
          if (!sk) begin
            sk <= 1'b1;
            if (data_bit) sh <= {sh[WORD_BITS-2:0], do_in};
          end else begin
            sk <= 1'b0;
            if (last_bit) begin
              cs <= 1'b0; di <= 1'b0; st <= R_GAP;
            end else begin
              k  <= k + KW'(1);
              di <= cmd_bit(int'(k) + 1, addr_q);
            end
          end
        end else ph <= ph + PW'(1);
        R_GAP: if (phase_end) begin
          ph <= '0; done <= 1'b1; word <= sh; st <= R_IDLE;
        end else ph <= ph + PW'(1);
        default: st <= R_IDLE;
      endcase
    end
  end

  // Checker state: observed rising edges per frame and high-phase length.
  logic          sk_d;
  logic [KW-1:0] rise_cnt;
  logic [PW:0]   hi_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sk_d <= 1'b0; rise_cnt <= '0; hi_cnt <= '0;
    end else begin
      sk_d     <= sk;
      rise_cnt <= !cs ? '0 : ((sk && !sk_d) ? rise_cnt + KW'(1) : rise_cnt);
      hi_cnt   <= sk ? hi_cnt + (PW+1)'(1) : '0;
    end
  end

  p_sk_in_frame_r2: assert property (@(posedge clk) disable iff (!rst_n)
    sk |-> cs);
  p_sk_high_width_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sk) |-> hi_cnt == (PW+1)'(HALF_CLKS));
  p_frame_edges_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs) |-> rise_cnt == KW'(TOTAL));
endmodule

// File: rtl/eeboot_cw_port.sv
module eeboot_cw_port (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        load,
  input  logic [7:0]  addr_in,
  input  logic [15:0] data_in,
  output logic        valid,
  output logic [7:0]  addr,
  output logic [15:0] data,
  input  logic        ready,
  output logic        fire
);
  assign fire = valid && ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid <= 1'b0; addr <= '0; data <= '0;
    end else if (load) begin
      valid <= 1'b1; addr <= addr_in; data <= data_in;
    end else if (fire) begin
      valid <= 1'b0;
    end
  end

  p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !ready) |=> (valid && $stable(addr) && $stable(data)));
  p_no_overwrite_r11: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> !valid);
endmodule

// File: rtl/eeboot_loader.sv
module eeboot_loader
  import eeboot_pkg::*;
#(
  parameter int          HALF_CLKS = 500,
  parameter int          ADDR_BITS = 6,
  parameter logic [7:0]  MAGIC     = 8'hAB,
  parameter logic [15:0] DEF_VID   = 16'h0ACE,
  parameter logic [15:0] DEF_PID   = 16'h0B01
) (
  input  logic        clk,
  input  logic        rst_n,
  output logic        ee_cs,
  output logic        ee_sk,
  output logic        ee_di,
  input  logic        ee_do,
  input  logic        rom_strap,
  output logic [15:0] vendor_id,
  output logic [15:0] product_id,
  output logic        ee_present,
  output logic        rom_opt,
  output logic        vol_sel,
  output logic        cw_valid,
  output logic [7:0]  cw_addr,
  output logic [15:0] cw_data,
  input  logic        cw_ready,
  output logic        boot_done
);
  localparam int IW = $clog2(TBL_LEN);

  typedef enum logic [2:0] {S_START, S_READ, S_DECIDE, S_WR, S_WRWAIT, S_DONE} state_e;

  state_e               st;
  phase_e               ph;
  logic [ADDR_BITS-1:0] rd_addr;
  logic [15:0]          vid_raw, pid_raw, ctrl_raw, pend_data;
  logic [7:0]           pend_addr;
  logic                 use_tbl;
  logic [IW-1:0]        tbl_idx;
  logic [3:0]           remain;

  // Named internal events.
  logic        rd_busy, rd_done, cw_fire;
  logic [15:0] rd_word;
  wire         rd_start  = (st == S_START);
  wire         wr_load   = (st == S_WR);
  wire         magic_hit = header_ok(ctrl_raw, MAGIC);
  wire [3:0]   regcnt    = ctrl_raw[11:8];
  cw_entry_t   tbl_entry;
  assign tbl_entry = dflt_entry(3'(tbl_idx));
  wire [7:0]   wr_addr   = use_tbl ? tbl_entry.addr : pend_addr;
  wire [15:0]  wr_data   = use_tbl ? tbl_entry.data : pend_data;

  eeboot_mw_reader #(.HALF_CLKS(HALF_CLKS), .ADDR_BITS(ADDR_BITS), .WORD_BITS(16)) u_rd (
    .clk(clk), .rst_n(rst_n), .start(rd_start), .addr(rd_addr),
    .busy(rd_busy), .done(rd_done), .word(rd_word),
    .cs(ee_cs), .sk(ee_sk), .di(ee_di), .do_in(ee_do)
  );

  eeboot_cw_port u_cw (
    .clk(clk), .rst_n(rst_n), .load(wr_load), .addr_in(wr_addr), .data_in(wr_data),
    .valid(cw_valid), .addr(cw_addr), .data(cw_data), .ready(cw_ready), .fire(cw_fire)
  );

  assign rom_opt = ee_present ? product_id[1] : rom_strap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_START; ph <= PH_VID; rd_addr <= '0;
      vid_raw <= '0; pid_raw <= '0; ctrl_raw <= '0;
      pend_addr <= '0; pend_data <= '0;
      use_tbl <= 1'b0; tbl_idx <= '0; remain <= '0;
      vendor_id <= DEF_VID; product_id <= DEF_PID;
      ee_present <= 1'b0; vol_sel <= 1'b0; boot_done <= 1'b0;
    end else begin
      unique case (st)
        S_START: st <= S_READ;
        S_READ: if (rd_done) begin
          unique case (ph)
            PH_VID:   begin vid_raw <= rd_word; ph <= PH_PID;  rd_addr <= rd_addr + 1'b1; st <= S_START; end
            PH_PID:   begin pid_raw <= rd_word; ph <= PH_CTRL; rd_addr <= rd_addr + 1'b1; st <= S_START; end
            PH_CTRL:  begin ctrl_raw <= rd_word; st <= S_DECIDE; end
            PH_PADDR: begin pend_addr <= rd_word[15:8]; ph <= PH_PDATA; rd_addr <= rd_addr + 1'b1; st <= S_START; end
            PH_PDATA: begin pend_data <= rd_word; st <= S_WR; end
            default:  st <= S_DONE;
          endcase
        end
        S_DECIDE: begin
          tbl_idx <= '0;
          if (magic_hit) begin
            ee_present <= 1'b1;
            vendor_id  <= vid_raw;
            product_id <= pid_raw;
            vol_sel    <= ctrl_raw[12];
            if (ctrl_raw[13]) begin
              use_tbl <= 1'b1; st <= S_WR;
            end else if (regcnt != 4'd0) begin
              use_tbl <= 1'b0; remain <= regcnt; ph <= PH_PADDR;
              rd_addr <= rd_addr + 1'b1; st <= S_START;
            end else begin
              st <= S_DONE;
            end
          end else begin
            use_tbl <= 1'b1; st <= S_WR;
          end
        end
        S_WR: st <= S_WRWAIT;
        S_WRWAIT: if (cw_fire) begin
          if (use_tbl) begin
            if (tbl_idx == IW'(TBL_LEN - 1)) st <= S_DONE;
            else begin tbl_idx <= tbl_idx + 1'b1; st <= S_WR; end
          end else if (remain == 4'd1) begin
            st <= S_DONE;
          end else begin
            remain <= remain - 4'd1; ph <= PH_PADDR;
            rd_addr <= rd_addr + 1'b1; st <= S_START;
          end
        end
        S_DONE: boot_done <= 1'b1;
        default: st <= S_DONE;
      endcase
    end
  end

  p_quiet_after_done_r12: assert property (@(posedge clk) disable iff (!rst_n)
    boot_done |-> (!ee_cs && !cw_valid && !rd_busy));
  p_done_sticky_r12: assert property (@(posedge clk) disable iff (!rst_n)
    boot_done |=> boot_done);
  p_ids_frozen_r4: assert property (@(posedge clk) disable iff (!rst_n)
    boot_done |=> ($stable(vendor_id) && $stable(product_id) && $stable(ee_present)));
  p_absent_defaults_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (boot_done && !ee_present) |-> (vendor_id == DEF_VID && product_id == DEF_PID && !vol_sel));
endmodule

// File: tb/eeboot_loader_bench.sv
module eeboot_loader_bench;
  localparam int          HALF = 2;
  localparam logic [15:0] DVID = 16'h0ACE;
  localparam logic [15:0] DPID = 16'h0B01;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ee_cs, ee_sk, ee_di, ee_do = 1'b0, rom_strap = 1'b0;
  logic [15:0] vendor_id, product_id, cw_data;
  logic [7:0]  cw_addr;
  logic ee_present, rom_opt, vol_sel, cw_valid, cw_ready = 1'b0, boot_done;

  always #2.5 clk = ~clk;

  eeboot_loader #(.HALF_CLKS(HALF), .DEF_VID(DVID), .DEF_PID(DPID)) u_eeboot_loader (
    .clk(clk), .rst_n(rst_n), .ee_cs(ee_cs), .ee_sk(ee_sk), .ee_di(ee_di), .ee_do(ee_do),
    .rom_strap(rom_strap), .vendor_id(vendor_id), .product_id(product_id),
    .ee_present(ee_present), .rom_opt(rom_opt), .vol_sel(vol_sel),
    .cw_valid(cw_valid), .cw_addr(cw_addr), .cw_data(cw_data), .cw_ready(cw_ready),
    .boot_done(boot_done)
  );

  int n_chk = 0, n_fail = 0;
  logic [15:0] mem [0:63];
  int rd_log [0:63];
  logic [23:0] wr_log [0:63];
  int rd_n = 0, wr_n = 0, rises = 0, frame_err = 0, timing_err = 0, hs_err = 0;
  logic [8:0] cmd = '0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // EEPROM model: command shifted in on rising SK, data driven after falling SK.
  always @(posedge ee_cs) begin rises = 0; cmd = '0; ee_do = 1'b0; end
  always @(posedge ee_sk) begin
    rises = rises + 1;
    if (rises <= 9) cmd = {cmd[7:0], ee_di};
    if (rises == 9) begin
      if (cmd[8:6] != 3'b110) frame_err++;
      if (rd_n < 64) rd_log[rd_n] = int'(cmd[5:0]);
      rd_n++;
    end
  end
  always @(negedge ee_sk) begin
    if (ee_cs && rises >= 10 && rises <= 25) ee_do = mem[cmd[5:0]][25 - rises];
    else ee_do = 1'b0;
  end

  // Serial timing and handshake observers.
  int hi_run = 0, lo_run = 1000, rdy_ctr = 0;
  logic pv = 1'b0, pr = 1'b0;
  logic [7:0] pa; logic [15:0] pd;
  always @(posedge clk) begin
    if (rst_n) begin
      if (ee_sk && !ee_cs) timing_err++;
      if (ee_sk) hi_run++;
      else begin
        if (hi_run != 0 && hi_run != HALF) timing_err++;
        hi_run = 0;
      end
      if (!ee_cs) lo_run++;
      else begin
        if (lo_run != 0 && lo_run < HALF) timing_err++;
        lo_run = 0;
      end
      if (pv && !pr && (!cw_valid || cw_addr != pa || cw_data != pd)) hs_err++;
      if (cw_valid && cw_ready) begin
        if (wr_n < 64) wr_log[wr_n] = {cw_addr, cw_data};
        wr_n++;
      end
      pv = cw_valid; pr = cw_ready; pa = cw_addr; pd = cw_data;
    end
  end
  always @(negedge clk) begin
    rdy_ctr++;
    cw_ready = (rdy_ctr % 3) != 0;
  end

  function automatic logic [23:0] exp_tbl(input int i);
    logic [23:0] t [0:6];
    t[0] = {8'h18, 16'h0808}; t[1] = {8'h10, 16'h8808}; t[2] = {8'h0E, 16'h0008};
    t[3] = {8'h04, 16'h0000}; t[4] = {8'h1A, 16'h0000}; t[5] = {8'h1C, 16'h0000};
    t[6] = {8'h2A, 16'h0001};
    return t[i];
  endfunction

  task automatic clear_mem();
    for (int i = 0; i < 64; i++) mem[i] = 16'h0;
  endtask

  task automatic boot_and_wait();
    int t = 0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rd_n = 0; wr_n = 0; frame_err = 0; timing_err = 0; hs_err = 0; pv = 1'b0;
    rst_n = 1'b1;
    while (!boot_done && t < 20000) begin @(negedge clk); t++; end
    chk("R12 boot_done reached", {31'd0, boot_done}, 32'd1);
    repeat (20) @(negedge clk);
    chk("R12 done stays high", {31'd0, boot_done}, 32'd1);
    chk("R12 cs low after done", {31'd0, ee_cs}, 32'd0);
    chk("R2 serial timing errors", timing_err, 0);
    chk("R3 command bits", frame_err, 0);
    chk("R11 handshake hold errors", hs_err, 0);
  endtask

  task automatic check_table_writes();
    chk("R6 table write count", wr_n, 7);
    for (int i = 0; i < 7; i++) chk("R6 table entry", wr_log[i], exp_tbl(i));
  endtask

  task automatic check_reads(input int n);
    chk("R3 word reads", rd_n, n);
    for (int i = 0; i < n && i < 64; i++) chk("R4 R7 read order", rd_log[i], i);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    chk("R1 cs", {31'd0, ee_cs}, 32'd0);
    chk("R1 sk", {31'd0, ee_sk}, 32'd0);
    chk("R1 cw_valid", {31'd0, cw_valid}, 32'd0);
    chk("R1 boot_done", {31'd0, boot_done}, 32'd0);
    chk("R1 ee_present", {31'd0, ee_present}, 32'd0);
    chk("R1 vendor_id", vendor_id, DVID);
    chk("R1 product_id", product_id, DPID);
  endtask

  task automatic t_bad_magic();
    clear_mem();
    mem[0] = 16'h1111; mem[1] = 16'h2222; mem[2] = 16'h30AA;
    rom_strap = 1'b1;
    boot_and_wait();
    chk("R5 present", {31'd0, ee_present}, 32'd0);
    chk("R5 vid default", vendor_id, DVID);
    chk("R5 pid default", product_id, DPID);
    chk("R5 vol_sel", {31'd0, vol_sel}, 32'd0);
    check_table_writes();
    check_reads(3);
    chk("R10 strap 1", {31'd0, rom_opt}, 32'd1);
    rom_strap = 1'b0;
    @(negedge clk);
    chk("R10 strap 0", {31'd0, rom_opt}, 32'd0);
  endtask

  task automatic t_builtin();
    clear_mem();
    mem[0] = 16'hC0DE; mem[1] = 16'h5A02; mem[2] = 16'hF5AB;
    mem[3] = 16'h7777; mem[4] = 16'h8888;
    rom_strap = 1'b0;
    boot_and_wait();
    chk("R4 present", {31'd0, ee_present}, 32'd1);
    chk("R4 vid", vendor_id, 16'hC0DE);
    chk("R4 pid", product_id, 16'h5A02);
    chk("R9 vol_sel with bits15:14 set", {31'd0, vol_sel}, 32'd1);
    chk("R10 from pid bit1", {31'd0, rom_opt}, 32'd1);
    check_table_writes();
    check_reads(3);
  endtask

  task automatic t_pairs3();
    clear_mem();
    mem[0] = 16'h1357; mem[1] = 16'h2468; mem[2] = 16'h03AB;
    mem[3] = 16'h2C55; mem[4] = 16'hBB44;
    mem[5] = 16'h3299; mem[6] = 16'h1234;
    mem[7] = 16'h0EFF; mem[8] = 16'h8001;
    boot_and_wait();
    chk("R7 write count", wr_n, 3);
    chk("R7 pair 0", wr_log[0], {8'h2C, 16'hBB44});
    chk("R7 pair 1", wr_log[1], {8'h32, 16'h1234});
    chk("R7 pair 2", wr_log[2], {8'h0E, 16'h8001});
    chk("R9 vol_sel 0", {31'd0, vol_sel}, 32'd0);
    check_reads(9);
  endtask

  task automatic t_zero_cnt();
    clear_mem();
    mem[0] = 16'hAAAA; mem[1] = 16'h5551; mem[2] = 16'h00AB;
    rom_strap = 1'b1;
    boot_and_wait();
    chk("R8 no writes", wr_n, 0);
    check_reads(3);
    chk("R8 present", {31'd0, ee_present}, 32'd1);
    chk("R10 pid bit1 0 over strap 1", {31'd0, rom_opt}, 32'd0);
  endtask

  task automatic t_pairs15();
    clear_mem();
    mem[0] = 16'h0001; mem[1] = 16'h0002; mem[2] = 16'h9FAB;
    for (int i = 0; i < 15; i++) begin
      mem[3 + 2*i] = {8'(i*3 + 1), 8'hA5};
      mem[4 + 2*i] = 16'(i * 16'h1111 + 7);
    end
    boot_and_wait();
    chk("R7 max count writes", wr_n, 15);
    for (int i = 0; i < 15; i++)
      chk("R7 max count pair", wr_log[i], {8'(i*3 + 1), 16'(i * 16'h1111 + 7)});
    chk("R9 vol_sel with bit15 set", {31'd0, vol_sel}, 32'd1);
    check_reads(33);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    t_reset();
    t_bad_magic();
    t_builtin();
    t_pairs3();
    t_zero_cnt();
    t_pairs15();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule